// File: doc/BRIEF.md
# Pulse-Position Downlink Symbol Decoder

This block turns the carrier-pause line of a contactless tag receiver into symbol values. The reader encodes each symbol by the position of a single carrier pause inside a fixed period: one of 256 positions (8 bits per symbol) or one of 4 positions (2 bits per symbol), selected by `mode_i`. The block runs on a sample clock already divided from the carrier clock. Its period counter advances only on cycles where the carrier is present, which models a front end that loses its clock during a pause. Each position is two 32-step slots wide, and the pause sits in the second slot. A symbol period therefore covers 64*N-32 counted steps, where N is 4 or 256.

The end of a pause is its rising carrier edge. When that edge arrives, the counter's upper field gives the position. The result is held until the period is over, and then it is released as a one-cycle `sym_valid_o` strobe carrying `sym_data_o`, or as a one-cycle `sym_err_o` strobe when the period held no pause or more than one. The pause for the highest position ends right at the period boundary, so it may finish in the first steps of the next period. For this reason a period's result is issued 16 counted steps into the following period. At the period boundary the counter restarts at 0, or slightly ahead when the last pause arrived early, so that a reader whose clock is a little fast does not build up drift. `frame_start_i` aligns the counter to the first symbol period of a stream. Frame delimiters and CRC handling lie outside this block.

Top module: `ppd_decoder`

## Requirements
- R1: A synchronous active-low reset clears the counter, the held results and the outputs. While in reset and afterwards, until a result is due, `sym_valid_o`, `sym_err_o` and `sym_data_o` are all zero.
- R2: With `mode_i`=0, the period is 16352 counted steps. A pause whose ending edge arrives at counted step 64*v+32 (steps numbered from 0 at the period start) yields `sym_data_o`=v with `sym_valid_o` high for exactly one cycle.
- R3: With `mode_i`=1, the period is 224 counted steps, decoding follows the same rule, and `sym_data_o` carries v in bits [1:0] with bits [7:2] zero.
- R4: The counter advances only on cycles where `carrier_i` is 1. It holds while `carrier_i` is 0 and wraps at the end of the period.
- R5: An ending edge at any counted step from 64*v+16 to 64*v+47 decodes as v.
- R6: The highest value (255 or 3) is decoded whether its ending edge arrives in the last 16 steps of its own period or in steps 0 to 15 of the next period. A spilled edge is credited to the earlier period and is never taken as a pause of the new one.
- R7: An ending edge in steps 0 to 15 of the first period after `frame_start_i` is ignored.
- R8: A period with no pause produces a one-cycle `sym_err_o` strobe with `sym_data_o`=0 and no valid strobe.
- R9: A period with two pauses produces a one-cycle `sym_err_o` strobe and no valid strobe. Decoding recovers in the next period.
- R10: A period's result is issued on the cycle after the counter steps from 15 to 16 in the following period, and not before.
- R11: When the accepted edge of a period arrives 4 or more steps early (residual (step-16) mod 64 of 12 or less), the next period starts at step 2 instead of 0. A reader whose periods are 2 counted steps short then keeps decoding correctly indefinitely.
- R12: `frame_start_i` restarts the counter at 0 and discards any result not yet issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (divided carrier clock) |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 1 | 0: 1-of-256 positions, 1: 1-of-4 positions |
| frame_start_i | input | 1 | Aligns the counter to the start of the first symbol period |
| carrier_i | input | 1 | Demodulated carrier: 1 present, 0 pause |
| sym_valid_o | output | 1 | One-cycle strobe for a decoded symbol |
| sym_data_o | output | 8 | Decoded position value |
| sym_err_o | output | 1 | One-cycle strobe for a period with bad pause timing |

## Verification
A counter that drifts or restarts at the wrong value first shows up as a pause landing in the wrong position. That appears as a wrong value, or as an error strobe for a symbol whose edge sits near a position border, within one period in 1-of-4 mode and within about ten periods under a steady 2-step reader drift. Wrong handling of the spill state shows at the ports as an extra strobe or a wrong value around the highest position, in the period after the spill. A lost or stale held result shows as a missing strobe, an extra strobe or a stale strobe 16 steps into the next period, or right after a new frame start.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
    // one half-position (carrier slot) and one full position, in counted steps
    localparam int SLOT_STEPS = 32;
    localparam int POS_STEPS  = 2 * SLOT_STEPS;
    localparam int POS_SH     = $clog2(POS_STEPS);
    localparam int OCTET_POS  = 256;
    localparam int PAIR_POS   = 4;

    typedef enum logic {
        MODE_OCTET = 1'b0,
        MODE_PAIR  = 1'b1
    } ppd_mode_e;
endpackage

// File: rtl/ppd_period_counter.sv
module ppd_period_counter
    import ppd_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int PRESET = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             mode_i,
    input  logic             trim_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] LEN_OCTET = CNT_W'(OCTET_POS * POS_STEPS - SLOT_STEPS);
    localparam logic [CNT_W-1:0] LEN_PAIR  = CNT_W'(PAIR_POS * POS_STEPS - SLOT_STEPS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] period;

    always_comb begin
        period = (ppd_mode_e'(mode_i) == MODE_PAIR) ? LEN_PAIR : LEN_OCTET;
        wrap_o = en_i && !clr_i && (st_q.cnt == period - 1'b1);
        st_d   = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (wrap_o) begin
            st_d.cnt = trim_i ? CNT_W'(PRESET) : '0;
        end else if (en_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R4: no movement while the carrier is paused
    a_r4_hold_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(st_q.cnt));

    // R4: the count stays inside the period of the selected mode
    a_r4_within_period: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |-> (st_q.cnt < period));

    // R11: a new period starts at zero or at the preset
    a_r11_restart_value: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (st_q.cnt == '0 || st_q.cnt == CNT_W'(PRESET)));
endmodule

// File: rtl/ppd_slot_capture.sv
module ppd_slot_capture
    import ppd_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int GUARD = 16,
    parameter int TRIM  = 4,
    localparam int DATA_W = CNT_W - POS_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic              edge_i,
    input  logic              wrap_i,
    input  logic              mode_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              early_o,
    output logic              valid_o,
    output logic              err_o,
    output logic [DATA_W-1:0] data_o
);
    localparam logic [POS_SH-1:0] EARLY_MAX = POS_SH'(SLOT_STEPS / 2 - TRIM);

    typedef struct packed {
        logic              have;
        logic              dup;
        logic [DATA_W-1:0] val;
    } period_rec_t;

    typedef struct packed {
        period_rec_t       cur;
        period_rec_t       prv;
        logic              prv_pend;
        logic              trim;
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } cap_state_t;

    cap_state_t        st_d, st_q, upd;
    logic [CNT_W-1:0]  off;
    logic [DATA_W-1:0] last_val;
    logic              emit;

    // effect of a pause-ending edge on the held records
    always_comb begin
        off      = cnt_i - CNT_W'(GUARD);
        last_val = (ppd_mode_e'(mode_i) == MODE_PAIR) ? DATA_W'(PAIR_POS - 1) : '1;
        upd      = st_q;
        if (edge_i) begin
            if (cnt_i < CNT_W'(GUARD)) begin
                // tail of the previous period's highest position
                if (st_q.prv_pend) begin
                    if (st_q.prv.have) begin
                        upd.prv.dup = 1'b1;
                    end else begin
                        upd.prv.have = 1'b1;
                        upd.prv.val  = last_val;
                    end
                end
            end else if (st_q.cur.have) begin
                upd.cur.dup = 1'b1;
            end else begin
                upd.cur.have = 1'b1;
                upd.cur.val  = off[CNT_W-1:POS_SH];
                upd.trim     = (off[POS_SH-1:0] <= EARLY_MAX);
            end
        end
    end

    assign early_o = upd.trim;

    always_comb begin
        st_d       = upd;
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;
        st_d.data  = '0;
        emit       = en_i && (cnt_i == CNT_W'(GUARD - 1)) && upd.prv_pend;
        if (emit) begin
            st_d.prv_pend = 1'b0;
            if (upd.prv.have && !upd.prv.dup) begin
                st_d.valid = 1'b1;
                st_d.data  = upd.prv.val;
            end else begin
                st_d.err = 1'b1;
            end
        end
        if (wrap_i) begin
            st_d.prv      = upd.cur;
            st_d.prv_pend = 1'b1;
            st_d.cur      = '0;
            st_d.trim     = 1'b0;
        end
        if (clr_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign err_o   = st_q.err;
    assign data_o  = st_q.data;

    // R8, R9: a period yields a value or an error, never both
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.valid && st_q.err));

    // R2: the valid strobe lasts one cycle
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    // R3: values in the 1-of-4 mode fit in two bits
    a_r3_pair_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && mode_i) |-> (st_q.data < DATA_W'(PAIR_POS)));

    // R10: results leave only as the counter passes the guard step
    a_r10_issue_point: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid || st_q.err) |-> ($past(cnt_i) == CNT_W'(GUARD - 1)));

    // R8: an error strobe carries zero data
    a_r8_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> (st_q.data == '0));
endmodule

// File: rtl/ppd_decoder.sv
module ppd_decoder
    import ppd_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int GUARD  = 16,
    parameter int TRIM   = 4,
    parameter int PRESET = 2,
    localparam int DATA_W = CNT_W - POS_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              frame_start_i,
    input  logic              carrier_i,
    output logic              sym_valid_o,
    output logic [DATA_W-1:0] sym_data_o,
    output logic              sym_err_o
);
    typedef struct packed {
        logic carrier;
    } line_state_t;

    line_state_t      ln_d, ln_q;
    logic             rise;
    logic             wrap;
    logic             early;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        ln_d.carrier = carrier_i;
        rise         = carrier_i && !ln_q.carrier;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q <= '{carrier: 1'b1};
        end else begin
            ln_q <= ln_d;
        end
    end

    ppd_period_counter #(
        .CNT_W  (CNT_W),
        .PRESET (PRESET)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (frame_start_i),
        .en_i   (carrier_i),
        .mode_i (mode_i),
        .trim_i (early),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    ppd_slot_capture #(
        .CNT_W (CNT_W),
        .GUARD (GUARD),
        .TRIM  (TRIM)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (frame_start_i),
        .en_i    (carrier_i),
        .edge_i  (rise),
        .wrap_i  (wrap),
        .mode_i  (mode_i),
        .cnt_i   (cnt),
        .early_o (early),
        .valid_o (sym_valid_o),
        .err_o   (sym_err_o),
        .data_o  (sym_data_o)
    );

    // R1: outputs stay quiet on the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sym_valid_o && !sym_err_o));
endmodule

// File: tb/ppd_decoder_tb_top.sv
module ppd_decoder_tb_top;
    localparam int LEN_PAIR  = 224;
    localparam int LEN_OCTET = 16352;

    logic       clk = 1'b0;
    logic       rst_n, mode, fstart, carrier;
    logic       vld, err;
    logic [7:0] dat;

    always #4 clk = ~clk;

    ppd_decoder dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode),
        .frame_start_i (fstart),
        .carrier_i     (carrier),
        .sym_valid_o   (vld),
        .sym_data_o    (dat),
        .sym_err_o     (err)
    );

    logic [8:0] exp_q[$];
    string      tag_q[$];
    int         checks = 0;
    int         errors = 0;
    int         carry  = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push_exp(input bit e, input int d, input string req);
        exp_q.push_back({e, 8'(d)});
        tag_q.push_back(req);
    endtask

    task automatic hi(input int n);
        carrier = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic lo(input int n);
        carrier = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input bit m);
        fstart  = 1'b1;
        mode    = m;
        carrier = 1'b1;
        @(negedge clk);
        fstart = 1'b0;
        carry  = 0;
    endtask

    // one reader symbol: edge at 64v+32+j counted steps, period of len steps
    task automatic sym(input int v, input int j, input int len);
        int a, b;
        a = 64 * v + 32 + j + carry;
        b = len - (64 * v + 32 + j);
        if (b < 0) begin
            carry = b;
            b = 0;
        end else begin
            carry = 0;
        end
        hi(a);
        lo(32);
        hi(b);
    endtask

    // monitor: pops the scoreboard whenever a strobe appears
    always @(negedge clk) begin
        if (rst_n && (vld || err)) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R7 R12 unexpected strobe actual=%0d expected=none", {err, dat});
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({err, dat} == e && !(vld && err), t, {err, dat}, e);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 1'b1; fstart = 1'b0; carrier = 1'b1;
        repeat (4) @(negedge clk);
        check(!vld && !err && dat == 8'd0, "R1 in reset", {vld, err, dat}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!vld && !err && dat == 8'd0, "R1 after release", {vld, err, dat}, 0);

        // R3, R6, R10: nominal 1-of-4 stream including the highest value
        start(1'b1);
        push_exp(0, 0, "R3 v0"); sym(0, 0, LEN_PAIR);
        push_exp(0, 1, "R3 v1"); sym(1, 0, LEN_PAIR);
        push_exp(0, 2, "R3 v2"); sym(2, 0, LEN_PAIR);
        push_exp(0, 3, "R6 v3 spill"); sym(3, 0, LEN_PAIR);
        push_exp(0, 2, "R10 v2"); sym(2, 0, LEN_PAIR);
        hi(15);
        check(exp_q.size() == 1, "R10 not before step 16", exp_q.size(), 1);
        hi(3);
        check(exp_q.size() == 0, "R10 issued at step 16", exp_q.size(), 0);

        // R5, R6: edges at the tolerance limits and early/late highest value
        start(1'b1);
        push_exp(0, 1, "R5 late +15"); sym(1, 15, LEN_PAIR);
        push_exp(0, 2, "R5 early -16"); sym(2, -16, LEN_PAIR);
        push_exp(0, 0, "R5 late +13"); sym(0, 13, LEN_PAIR);
        push_exp(0, 3, "R6 early last"); sym(3, -10, LEN_PAIR);
        push_exp(0, 3, "R6 late last"); sym(3, 10, LEN_PAIR);
        push_exp(0, 1, "R6 after spill"); sym(1, 0, LEN_PAIR);
        hi(20);

        // R8, R9: missing and doubled pauses, then recovery
        start(1'b1);
        push_exp(1, 0, "R8 no pause"); hi(LEN_PAIR);
        push_exp(1, 0, "R9 two pauses"); hi(32); lo(32); hi(64); lo(32); hi(128);
        push_exp(0, 2, "R9 recovery"); sym(2, 0, LEN_PAIR);
        hi(20);

        // R7: edge right after frame start is ignored
        start(1'b1);
        lo(32);
        push_exp(0, 1, "R7 first period"); sym(1, 0, LEN_PAIR);
        hi(20);

        // R12: frame start drops an unissued result
        start(1'b1);
        sym(2, 0, LEN_PAIR);
        start(1'b1);
        push_exp(0, 0, "R12 after restart"); sym(0, 0, LEN_PAIR);
        hi(20);

        // R11: reader periods two steps short
        start(1'b1);
        for (int i = 0; i < 14; i++) begin
            push_exp(0, i % 3, "R11 drift");
            sym(i % 3, 0, LEN_PAIR - 2);
        end
        hi(20);

        // R2, R6: 1-of-256 stream
        start(1'b0);
        push_exp(0, 8'h00, "R2 v00"); sym(8'h00, 0, LEN_OCTET);
        push_exp(0, 8'h5A, "R2 v5A"); sym(8'h5A, 7, LEN_OCTET);
        push_exp(0, 8'hFF, "R6 vFF late"); sym(8'hFF, 9, LEN_OCTET);
        push_exp(0, 8'hFF, "R6 vFF early"); sym(8'hFF, -9, LEN_OCTET);
        push_exp(0, 8'h81, "R2 v81"); sym(8'h81, 0, LEN_OCTET);
        hi(20);
        check(exp_q.size() == 0, "R2 all results issued", exp_q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule